// File: doc/BRIEF.md
# Receive Frame Checksum Engine

This block sits beside a receive byte stream and forms a 16-bit ones' complement sum over the part of each Ethernet frame that follows the link-layer headers. Software can then use this sum when it checks upper-layer checksums without reading the payload a second time. Bytes arrive one per beat with start and end markers. A per-beat flag tags the trailing frame check sequence (FCS) bytes, which are never summed. A mode input, sampled on the first beat of each frame, selects where the sum begins.

In mode 0 the sum starts at byte offset 14, right after the destination, source and type fields. In mode 1 the block reads the type field. It steps over up to two 4-byte VLAN tags that carry type 0x8100. It also steps over an 8-byte LLC/SNAP header when the field after the tags holds a length below 0x0600. Summing then begins at the first byte after the last header. The result appears with a one-cycle done pulse after the frame's final beat.

The input is a valid/ready stream. The block never applies back-pressure: `in_ready` stays high, every beat with `in_valid` high is consumed in that cycle, and cycles with `in_valid` low are idle and change nothing.

Top module: `rx_csum_offload`

## Requirements
- R1: The result is the 16-bit ones' complement sum with end-around carry of the summed bytes, taken as big-endian 16-bit words (first byte is the high byte).
- R2: With mode 0 selected, summing starts at byte offset 14 of the frame (offset 0 is the start-of-frame beat).
- R3: A beat whose `in_fcs` flag is high is never added to the sum. A frame with no flagged beats is summed up to its last byte.
- R4: If the summed region holds an odd number of bytes, the last byte is paired with a zero low byte.
- R5: With mode 1, when the two bytes at the current type offset (first at offset 12) equal 0x8100 and fewer than two tags have been skipped, those 4 bytes are skipped and the type offset moves up by 4. A third 0x8100 is treated as an ordinary type.
- R6: With mode 1, once a type value that is not a skipped tag is read, summing starts 2 bytes after the type offset when the value is 0x0600 or above. When the value is below 0x0600, summing starts 10 bytes after the type offset, so an 8-byte SNAP header is also skipped.
- R7: The mode is taken from `mode_sel` on the start-of-frame beat only. Changes on later beats of the frame have no effect.
- R8: `csum_done` is high for exactly the one cycle after the end-of-frame beat is accepted. `csum_out` carries that frame's result in that cycle and keeps it until the next frame's done pulse.
- R9: A frame that ends before its summing window begins yields a result of 0x0000.
- R10: `in_ready` is high at all times. Cycles with `in_valid` low do not alter the sum, the byte position or the outputs.
- R11: After reset, `csum_out` is 0x0000 and `csum_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat present |
| in_ready | output | 1 | Always high; the block takes every beat |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_fcs | input | 1 | Beat is an FCS byte and is not summed |
| mode_sel | input | 1 | Window mode, 0 = fixed header, 1 = parse tags and SNAP |
| csum_out | output | 16 | Checksum of the most recent frame |
| csum_done | output | 1 | One-cycle pulse when a new result is presented |

## Verification
Each internal error reaches the ports only at the next done pulse, one cycle after the end-of-frame beat. No intermediate sum is visible before then, so every check compares a whole frame's result against a model. A slip in the byte position or in the parsed window start moves the summing boundary, and this changes the result for almost any random payload. An error in the byte pairing or the carry fold shows only for odd-length regions or sums that overflow, so the bench aims directed frames at those cases. After each pulse the bench also checks that the done flag drops and the held result stays the same.

// File: rtl/rxcsum_pkg.sv
package rxcsum_pkg;

  // 16-bit ones' complement addition with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

endpackage

// File: rtl/rxcsum_parser.sv
module rxcsum_parser #(
  parameter int          POS_W     = 16,
  parameter int          HDR_LEN   = 14,
  parameter int          TYPE_OFF  = 12,
  parameter int          MAX_TAGS  = 2,
  parameter int          TAG_LEN   = 4,
  parameter int          SNAP_LEN  = 8,
  parameter logic [15:0] VLAN_TPID = 16'h8100,
  parameter logic [15:0] LEN_LIMIT = 16'h0600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       sof,
  input  logic       fcs,
  input  logic       mode,
  input  logic [7:0] data,
  output logic       in_win
);
  localparam int              TAG_W   = $clog2(MAX_TAGS + 1);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] HDR_P   = POS_W'(HDR_LEN);
  localparam logic [POS_W-1:0] TOFF_P  = POS_W'(TYPE_OFF);

  logic [POS_W-1:0] pos_q, toff_q, win_q;
  logic [TAG_W-1:0] tags_q;
  logic             mode_q;
  logic [7:0]       prev_q;

  logic [POS_W-1:0] cur_pos, cur_toff, cur_win, toff_n, win_n;
  logic [TAG_W-1:0] cur_tags, tags_n;
  logic             cur_mode, at_type;
  logic [15:0]      type_word;

  always_comb begin
    cur_pos   = sof ? '0 : pos_q;
    cur_mode  = sof ? mode : mode_q;
    cur_toff  = sof ? TOFF_P : toff_q;
    cur_tags  = sof ? '0 : tags_q;
    cur_win   = sof ? (mode ? POS_MAX : HDR_P) : win_q;
    type_word = {prev_q, data};
    at_type   = cur_mode && (cur_pos == cur_toff + POS_W'(1));
    toff_n    = cur_toff;
    tags_n    = cur_tags;
    win_n     = cur_win;
    if (at_type) begin
      if (type_word == VLAN_TPID && cur_tags < TAG_W'(MAX_TAGS)) begin
        toff_n = cur_toff + POS_W'(TAG_LEN);
        tags_n = cur_tags + TAG_W'(1);
      end else if (type_word < LEN_LIMIT) begin
        win_n = cur_toff + POS_W'(2 + SNAP_LEN);
      end else begin
        win_n = cur_toff + POS_W'(2);
      end
    end
    in_win = beat && !fcs && (cur_pos >= cur_win);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      toff_q <= TOFF_P;
      win_q  <= HDR_P;
      tags_q <= '0;
      mode_q <= 1'b0;
      prev_q <= '0;
    end else if (beat) begin
      pos_q  <= (cur_pos == POS_MAX) ? cur_pos : cur_pos + POS_W'(1);
      toff_q <= toff_n;
      win_q  <= win_n;
      tags_q <= tags_n;
      mode_q <= cur_mode;
      prev_q <= data;
    end
  end

  // R5
  tag_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tags_q <= TAG_W'(MAX_TAGS));

  // R2
  win_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_q >= HDR_P);

  // R10
  pos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(pos_q));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !sof) |=> $stable(mode_q));

endmodule

// File: rtl/rxcsum_accum.sv
module rxcsum_accum
  import rxcsum_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat,
  input  logic        sof,
  input  logic        eof,
  input  logic        in_win,
  input  logic [7:0]  data,
  output logic [15:0] csum,
  output logic        done
);
  logic [15:0] acc_q, csum_q;
  logic [7:0]  hi_q;
  logic        hv_q, done_q;

  logic [15:0] base_acc, acc1, fin;
  logic [7:0]  hi1;
  logic        base_hv, hv1;

  always_comb begin
    base_acc = sof ? 16'h0000 : acc_q;
    base_hv  = sof ? 1'b0 : hv_q;
    acc1     = base_acc;
    hv1      = base_hv;
    hi1      = hi_q;
    if (in_win) begin
      if (base_hv) begin
        acc1 = oc_add(base_acc, {hi_q, data});
        hv1  = 1'b0;
      end else begin
        hi1 = data;
        hv1 = 1'b1;
      end
    end
    fin = hv1 ? oc_add(acc1, {hi1, 8'h00}) : acc1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      hi_q   <= '0;
      hv_q   <= 1'b0;
      csum_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= beat && eof;
      if (beat) begin
        acc_q <= acc1;
        hi_q  <= hi1;
        hv_q  <= hv1;
        if (eof) csum_q <= fin;
      end
    end
  end

  assign csum = csum_q;
  assign done = done_q;

  // R8
  done_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && eof) |=> done);

  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(beat && eof));

  // R8
  csum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(csum));

  // R10
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> ($stable(acc_q) && $stable(hv_q)));

endmodule

// File: rtl/rx_csum_offload.sv
module rx_csum_offload #(
  parameter int POS_W    = 16,
  parameter int HDR_LEN  = 14,
  parameter int MAX_TAGS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        in_fcs,
  input  logic        mode_sel,
  output logic [15:0] csum_out,
  output logic        csum_done
);
  logic beat, in_win;

  assign in_ready = 1'b1;
  assign beat     = in_valid;

  rxcsum_parser #(
    .POS_W   (POS_W),
    .HDR_LEN (HDR_LEN),
    .MAX_TAGS(MAX_TAGS)
  ) u_parser (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (beat),
    .sof   (in_sof),
    .fcs   (in_fcs),
    .mode  (mode_sel),
    .data  (in_data),
    .in_win(in_win)
  );

  rxcsum_accum u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (beat),
    .sof   (in_sof),
    .eof   (in_eof),
    .in_win(in_win),
    .data  (in_data),
    .csum  (csum_out),
    .done  (csum_done)
  );

endmodule

// File: tb/tb_rx_csum_offload.sv
`timescale 1ns/1ps
module tb_rx_csum_offload;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0, in_eof = 1'b0, in_fcs = 1'b0, mode_sel = 1'b0;
  logic [15:0] csum_out;
  logic        csum_done;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] frm [0:127];

  always #2 clk = ~clk;

  rx_csum_offload dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_fcs(in_fcs),
    .mode_sel(mode_sel), .csum_out(csum_out), .csum_done(csum_done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_sum(input int len, input bit md, input bit hasf);
    int start, e, t, tags;
    bit stop;
    logic [15:0] ty;
    int unsigned s;
    start = 1 << 30;
    if (!md) start = 14;
    else begin
      t = 12; tags = 0; stop = 0;
      for (int k = 0; k < 4 && !stop; k++) begin
        if (t + 1 >= len) stop = 1;
        else begin
          ty = {frm[t], frm[t+1]};
          if (ty == 16'h8100 && tags < 2) begin t += 4; tags++; end
          else begin start = (ty < 16'h0600) ? t + 10 : t + 2; stop = 1; end
        end
      end
    end
    e = hasf ? len - 4 : len;
    s = 0;
    for (int i = start; i < e; i += 2)
      s += {frm[i], (i + 1 < e) ? frm[i+1] : 8'h00};
    while (s >> 16 != 0) s = (s & 32'hFFFF) + (s >> 16);
    return s[15:0];
  endfunction

  task automatic build(input int len, input int ntags, input bit snap);
    for (int i = 0; i < 128; i++) frm[i] = 8'($urandom);
    for (int k = 0; k < ntags; k++) begin
      frm[12 + 4*k] = 8'h81; frm[13 + 4*k] = 8'h00;
    end
    frm[12 + 4*ntags] = snap ? 8'h00 : 8'h08;
    frm[13 + 4*ntags] = snap ? 8'h40 : 8'h00;
    if (len < 0) frm[0] = 8'h00;
  endtask

  // Drives one frame and checks done, result and hold; exp_force >= 0 overrides the model
  task automatic send(input int len, input bit md, input bit hasf, input bit gaps,
                      input string req, input int exp_force);
    logic [15:0] exp, held;
    exp = (exp_force >= 0) ? 16'(exp_force) : ref_sum(len, md, hasf);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (gaps && ($urandom % 4 == 0)) begin
        in_valid = 1'b0;
        mode_sel = 1'($urandom);
        in_data  = 8'($urandom);
        repeat (1 + $urandom % 3) @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = frm[i];
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_fcs   = hasf && (i >= len - 4);
      mode_sel = (i == 0) ? md : 1'($urandom);
      if (i > 0 && i < len - 1) check(csum_done == 1'b0, "R8 early done", 32'(csum_done), 0);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_fcs = 1'b0;
    check(csum_done == 1'b1, "R8 done pulse", 32'(csum_done), 1);
    check(csum_out == exp, req, 32'(csum_out), 32'(exp));
    held = csum_out;
    repeat (2) @(negedge clk);
    check(csum_done == 1'b0, "R8 single pulse", 32'(csum_done), 0);
    check(csum_out == held, "R8 hold", 32'(csum_out), 32'(held));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state, R10 ready
    check(csum_out == 16'h0000, "R11 reset csum", 32'(csum_out), 0);
    check(csum_done == 1'b0, "R11 reset done", 32'(csum_done), 0);
    check(in_ready == 1'b1, "R10 ready high", 32'(in_ready), 1);

    // R1 carry wrap: FFFF + 0002 -> 0002
    build(18, 0, 0);
    frm[14] = 8'hFF; frm[15] = 8'hFF; frm[16] = 8'h00; frm[17] = 8'h02;
    send(18, 1'b0, 1'b0, 1'b0, "R1 end-around carry", 16'h0002);
    // R2 mode 0 even length with FCS (R3)
    build(64, 0, 0);
    send(64, 1'b0, 1'b1, 1'b0, "R2 R3 mode0 window", -1);
    // R4 odd region: 15 bytes -> one padded byte
    build(15, 0, 0);
    frm[14] = 8'hAB;
    send(15, 1'b0, 1'b0, 1'b0, "R4 odd pad", 16'hAB00);
    build(61, 0, 0);
    send(61, 1'b0, 1'b1, 1'b1, "R4 odd with gaps R10", -1);
    // R9 short frames
    build(10, 0, 0);
    send(10, 1'b0, 1'b0, 1'b0, "R9 short mode0", 16'h0000);
    build(18, 0, 0);
    send(18, 1'b0, 1'b1, 1'b0, "R9 R3 window all FCS", 16'h0000);
    build(16, 1, 0);
    send(16, 1'b1, 1'b0, 1'b0, "R9 short mode1 tag", 16'h0000);
    // R5 tags, R6 type/SNAP
    build(48, 1, 0);
    send(48, 1'b1, 1'b1, 1'b0, "R5 one tag", -1);
    build(50, 2, 1);
    send(50, 1'b1, 1'b1, 1'b0, "R5 R6 two tags SNAP", -1);
    build(52, 3, 0);
    send(52, 1'b1, 1'b1, 1'b0, "R5 third tag as type", -1);
    build(40, 0, 1);
    send(40, 1'b1, 1'b0, 1'b0, "R6 SNAP no tags R3", -1);
    // R7: mode 1 frame run in mode 0 differs by window
    build(40, 1, 0);
    send(40, 1'b0, 1'b1, 1'b1, "R7 mode latched at sof", -1);

    for (int n = 0; n < 60; n++) begin
      int len = 8 + int'($urandom % 121);
      build(len, int'($urandom % 4), 1'($urandom));
      send(len, 1'($urandom), 1'($urandom), 1'($urandom), "R1 R6 random frame", -1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule